// File: doc/BRIEF.md
# Configuration Port Decoder

This block sits on the I/O-space request path of a processor and sorts every I/O access into one of three destinations. It holds a 32-bit configuration address register. An access to the address port with a full dword size reaches that register. An access to the four-byte data window is turned into a configuration-space access, but only when the register's top bit is set. Every other access passes through unchanged as plain I/O.

For each valid request the block returns a target code and a routed address one clock later. Reads of the address register also return its contents. Software uses it in two steps. First it writes an enabled address to the address port. Then it reads or writes the data window, and those accesses are redirected to the configuration location named by that address. The bus transactions that follow are handled elsewhere.

Top module: `cfgport_decoder`

## Requirements
- R1: A request to port 0xCF8 with a size of exactly 4 bytes gets target code 1 (address register), and its routed address is the port number zero-extended.
- R2: A request to port 0xCF8 with any size other than 4 gets target code 0 (plain I/O), and its routed address is 0x00000CF8.
- R3: A request to ports 0xCFC to 0xCFF while bit 31 of the address register is set gets target code 2 (configuration). Its routed address is bits 30:0 of the register, with bit 31 zero, OR'd with the low two port bits.
- R4: A request to ports 0xCFC to 0xCFF while bit 31 of the address register is clear gets target code 0, and its routed address is the port number.
- R5: A request to any other 16-bit port gets target code 0, and its routed address is the port number.
- R6: A write that matches R1 loads the write data into the address register at the next clock edge, so the request in the next cycle already decodes with the new value. No other request changes the register.
- R7: A read that matches R1 returns the register contents on the read data output. Every other response carries zero read data.
- R8: Reset clears the address register to zero, so data-window accesses go to plain I/O until an enabled address is written.
- R9: Each request produces exactly one response, one cycle after it is presented. No response appears in a cycle that follows an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_port | input | 16 | I/O port number |
| req_size | input | 3 | Access size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_target | output | 2 | 0 plain I/O, 1 address register, 2 configuration |
| rsp_addr | output | 32 | Routed address |
| rsp_rdata | output | 32 | Address register contents on a register read, else zero |

## Verification
The hardest case to reach is a write to the address port followed, in the very next cycle, by a data-window access. That is where a decoder that uses a stale register value would still look correct if any idle cycle came between the two. The stimulus therefore sends the two requests back to back with no gap. It also covers both enable states, all four byte lanes, and full-scale register contents. In addition, short-size and data-window writes are sent and then followed by a read of the register, which shows that they left it unchanged.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
   typedef enum logic [1:0] {
      TGT_IO   = 2'd0,
      TGT_AREG = 2'd1,
      TGT_CFG  = 2'd2
   } route_tgt_e;
endpackage

// File: rtl/cfgport_classify.sv
module cfgport_classify
   import cfgport_pkg::*;
#(
   parameter int PORT_W    = 16,
   parameter int SIZE_W    = 3,
   parameter int WIN_BITS  = 2,
   parameter int REG_BYTES = 4,
   parameter logic [PORT_W-1:0] ADDR_PORT = 16'hCF8,
   parameter logic [PORT_W-1:0] DATA_PORT = 16'hCFC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic [PORT_W-1:0] port,
   input  logic [SIZE_W-1:0] size,
   input  logic              enable,
   output route_tgt_e        tgt
);
   localparam logic [SIZE_W-1:0] REG_SIZE = SIZE_W'(REG_BYTES);

   logic hit_areg;
   logic hit_window;

   assign hit_areg   = (port == ADDR_PORT) && (size == REG_SIZE);
   assign hit_window = (port[PORT_W-1:WIN_BITS] == DATA_PORT[PORT_W-1:WIN_BITS]);

   always_comb begin
      if (hit_areg)                  tgt = TGT_AREG;
      else if (hit_window && enable) tgt = TGT_CFG;
      else                           tgt = TGT_IO;
   end

   // R1: address-register target only on the exact port with the full size
   p_areg_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && tgt == TGT_AREG) |-> (port == ADDR_PORT && size == REG_SIZE));

   // R3: configuration target requires the enable bit and the window
   p_cfg_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && tgt == TGT_CFG) |-> (enable &&
         port[PORT_W-1:WIN_BITS] == DATA_PORT[PORT_W-1:WIN_BITS]));

   // R5: ports outside both decodes fall through to plain I/O
   p_other_io_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && port != ADDR_PORT &&
       port[PORT_W-1:WIN_BITS] != DATA_PORT[PORT_W-1:WIN_BITS]) |-> (tgt == TGT_IO));
endmodule

// File: rtl/cfgport_addr_reg.sv
module cfgport_addr_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (wr_en) q <= wdata;
   end

   // R6: a qualifying write is visible after the next edge
   p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (q == $past(wdata)));

   // R6: nothing else changes the register
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q));
endmodule

// File: rtl/cfgport_route.sv
module cfgport_route
   import cfgport_pkg::*;
#(
   parameter int PORT_W   = 16,
   parameter int ADDR_W   = 32,
   parameter int WIN_BITS = 2
) (
   input  route_tgt_e        tgt,
   input  logic [PORT_W-1:0] port,
   input  logic [ADDR_W-1:0] areg,
   output logic [ADDR_W-1:0] addr
);
   localparam int PAD_W = ADDR_W - PORT_W;

   logic [ADDR_W-1:0] port_ext;
   logic [ADDR_W-1:0] cfg_addr;

   generate
      if (PAD_W > 0) begin : g_pad
         assign port_ext = {{PAD_W{1'b0}}, port};
      end else begin : g_nopad
         assign port_ext = port;
      end
   endgenerate

   assign cfg_addr = {1'b0, areg[ADDR_W-2:0]} |
                     {{(ADDR_W-WIN_BITS){1'b0}}, port[WIN_BITS-1:0]};

   always_comb begin
      case (tgt)
         TGT_CFG: addr = cfg_addr;
         default: addr = port_ext;
      endcase
   end
endmodule

// File: rtl/cfgport_decoder.sv
module cfgport_decoder
   import cfgport_pkg::*;
#(
   parameter int PORT_W       = 16,
   parameter int ADDR_W       = 32,
   parameter int SIZE_W       = 3,
   parameter int WIN_BITS     = 2,
   parameter int REG_BYTES    = 4,
   parameter logic [PORT_W-1:0] ADDR_PORT = 16'hCF8,
   parameter logic [PORT_W-1:0] DATA_PORT = 16'hCFC,
   parameter bit REGISTER_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [PORT_W-1:0] req_port,
   input  logic [SIZE_W-1:0] req_size,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [1:0]        rsp_target,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic [ADDR_W-1:0] rsp_rdata
);
   localparam int EN_BIT = ADDR_W - 1;

   if (PORT_W < WIN_BITS + 1) $error("PORT_W too narrow for window");
   if (ADDR_W < PORT_W)       $error("ADDR_W must cover a port number");
   if (REG_BYTES >= (1 << SIZE_W)) $error("SIZE_W cannot encode REG_BYTES");
   if (WIN_BITS < 1)          $error("WIN_BITS must be at least 1");

   route_tgt_e        dec_tgt;
   logic [ADDR_W-1:0] areg_q;
   logic [ADDR_W-1:0] dec_addr;
   logic [ADDR_W-1:0] dec_rdata;
   logic              areg_wr;

   cfgport_classify #(
      .PORT_W(PORT_W), .SIZE_W(SIZE_W), .WIN_BITS(WIN_BITS),
      .REG_BYTES(REG_BYTES), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
   ) u_classify (
      .clk(clk), .rst_n(rst_n), .valid(req_valid), .port(req_port),
      .size(req_size), .enable(areg_q[EN_BIT]), .tgt(dec_tgt)
   );

   assign areg_wr = req_valid && req_write && (dec_tgt == TGT_AREG);

   cfgport_addr_reg #(.W(ADDR_W)) u_areg (
      .clk(clk), .rst_n(rst_n), .wr_en(areg_wr), .wdata(req_wdata), .q(areg_q)
   );

   cfgport_route #(
      .PORT_W(PORT_W), .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)
   ) u_route (
      .tgt(dec_tgt), .port(req_port), .areg(areg_q), .addr(dec_addr)
   );

   assign dec_rdata = (req_valid && !req_write && dec_tgt == TGT_AREG) ? areg_q : '0;

   generate
      if (REGISTER_OUT) begin : g_reg_out
         logic [ADDR_W-1:0] port_ext;
         assign port_ext = ADDR_W'(req_port);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rsp_valid  <= 1'b0;
               rsp_target <= TGT_IO;
               rsp_addr   <= '0;
               rsp_rdata  <= '0;
            end else begin
               rsp_valid  <= req_valid;
               rsp_target <= req_valid ? dec_tgt : TGT_IO;
               rsp_addr   <= req_valid ? dec_addr : '0;
               rsp_rdata  <= dec_rdata;
            end
         end

         // R9: one response per request, one cycle later
         p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid |=> rsp_valid);
         // R4: plain I/O responses carry the requested port
         p_io_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && dec_tgt == TGT_IO) |=> (rsp_addr == $past(port_ext)));
         // R7: read data only on a register read
         p_rdata_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_target != TGT_AREG) |-> (rsp_rdata == '0));
      end else begin : g_comb_out
         assign rsp_valid  = req_valid;
         assign rsp_target = req_valid ? dec_tgt : TGT_IO;
         assign rsp_addr   = req_valid ? dec_addr : '0;
         assign rsp_rdata  = dec_rdata;
      end
   endgenerate
endmodule

// File: tb/cfgport_decoder_tb.sv
module cfgport_decoder_tb;
   typedef struct {
      int          req;
      logic [1:0]  tgt;
      logic [31:0] addr;
      logic [31:0] rdata;
      logic        valid;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_port = '0;
   logic [2:0]  req_size = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [1:0]  rsp_target;
   logic [31:0] rsp_addr;
   logic [31:0] rsp_rdata;

   int   checks = 0;
   int   failures = 0;
   bit   done = 1'b0;
   exp_t sb[$];
   logic [31:0] mreg = '0;

   always #10 clk = ~clk;

   cfgport_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
      .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_target(rsp_target), .rsp_addr(rsp_addr),
      .rsp_rdata(rsp_rdata)
   );

   // driver: one call per cycle, pushes the expected response
   task automatic send(input bit v, input logic [15:0] p, input logic [2:0] sz,
                       input bit wr, input logic [31:0] wd, input int rq);
      exp_t e;
      @(negedge clk);
      req_valid = v; req_port = p; req_size = sz; req_write = wr; req_wdata = wd;
      e.req = rq; e.valid = v; e.rdata = '0;
      if (p == 16'hCF8 && sz == 3'd4) begin
         e.tgt = 2'd1; e.addr = {16'h0, p};
         if (!wr) e.rdata = mreg;
      end else if (p[15:2] == 14'h033F && mreg[31]) begin
         e.tgt = 2'd2; e.addr = {1'b0, mreg[30:0]} | {30'h0, p[1:0]};
      end else begin
         e.tgt = 2'd0; e.addr = {16'h0, p};
      end
      if (!v) begin e.tgt = 2'd0; e.addr = '0; e.rdata = '0; end
      sb.push_back(e);
      if (v && wr && p == 16'hCF8 && sz == 3'd4) mreg = wd;
   endtask

   task automatic idle(input int rq);
      send(1'b0, 16'h0, 3'd0, 1'b0, 32'h0, rq);
   endtask

   // monitor: pops and compares away from the clock edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (rsp_valid !== e.valid || rsp_target !== e.tgt ||
                rsp_addr !== e.addr || rsp_rdata !== e.rdata) begin
               failures++;
               $display("FAIL R%0d: got v=%0b t=%0d a=%h d=%h exp v=%0b t=%0d a=%h d=%h",
                        e.req, rsp_valid, rsp_target, rsp_addr, rsp_rdata,
                        e.valid, e.tgt, e.addr, e.rdata);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #5;
      checks++;
      if (rsp_valid !== 1'b0) begin
         failures++;
         $display("FAIL R8: got rsp_valid=%0b exp 0 in reset", rsp_valid);
      end
      @(negedge clk) rst_n = 1'b1;

      send(1, 16'hCF8, 3'd4, 0, 0, 8);                // R8 register is zero, R7 read
      send(1, 16'hCFC, 3'd4, 0, 0, 8);                // R8 window goes to I/O
      send(1, 16'hCF8, 3'd4, 1, 32'h8000_1234, 6);    // R6 write
      send(1, 16'hCFD, 3'd1, 0, 0, 6);                // R6 back to back, R3 lane 1
      send(1, 16'hCFC, 3'd4, 1, 32'hDEAD_BEEF, 3);    // R3 lane 0 write
      send(1, 16'hCFE, 3'd2, 0, 0, 3);                // R3 lane 2
      send(1, 16'hCFF, 3'd1, 1, 32'h55, 3);           // R3 lane 3
      send(1, 16'hCF8, 3'd4, 0, 0, 7);                // R7 data writes left register alone
      send(1, 16'hCF8, 3'd2, 1, 32'h0, 2);            // R2 short write
      send(1, 16'hCF8, 3'd1, 0, 0, 2);                // R2 byte read
      send(1, 16'hCF8, 3'd4, 0, 0, 6);                // R6 short write ignored
      idle(9);                                        // R9 idle gives no response
      idle(9);
      send(1, 16'h0080, 3'd1, 0, 0, 5);               // R5
      send(1, 16'hCF9, 3'd1, 0, 0, 5);                // R5 next to address port
      send(1, 16'hCFB, 3'd1, 0, 0, 5);                // R5 below window
      send(1, 16'hD00, 3'd4, 0, 0, 5);                // R5 above window
      send(1, 16'hFFFF, 3'd1, 1, 32'h1, 5);           // R5 top port
      send(1, 16'hCF8, 3'd4, 1, 32'h7FFF_FFF0, 4);    // R4 enable clear
      send(1, 16'hCFC, 3'd4, 0, 0, 4);                // R4
      send(1, 16'hCFF, 3'd1, 1, 32'h9, 4);            // R4
      send(1, 16'hCF8, 3'd4, 1, 32'hFFFF_FFFC, 3);    // R3 full scale
      send(1, 16'hCFF, 3'd1, 0, 0, 3);                // R3 address 0x7FFFFFFF
      send(1, 16'hCF8, 3'd4, 0, 0, 1);                // R1 read back
      idle(9);
      idle(9);
      @(negedge clk);
      @(negedge clk);
      checks++;
      if (sb.size() != 0) begin
         failures++;
         $display("FAIL R9: got %0d pending exp 0", sb.size());
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule